// File: doc/BRIEF.md
# PPS Time-of-Day Counter

This block keeps the time of day for a timing node. It holds a seconds count and a sub-second count of reference-clock cycles, and both advance on the reference clock. When the sub-second count passes its last value it returns to zero, the seconds count steps by one, and a pulse-per-second output goes high for one cycle.

Software stages new time values through a simple write port. There are three staging registers: the low word of the seconds value, the high word of the seconds value, and the sub-second value. A write to the command select issues one-shot load commands. One command copies the staged seconds into the seconds counter and leaves the sub-second counter running. The other copies the staged sub-second value into the sub-second counter and leaves the seconds counter alone. A status output tells downstream logic whether the time outputs hold a loaded, meaningful timecode.

With the default parameters the block suits a 125 MHz reference. It then counts 8 ns cycles and wraps after count 124999999. The seconds counter is 40 bits wide, loaded from a 32-bit low word and an 8-bit high word.

Top module: `tod_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `secOut`, `subOut`, `ppsPulse` and `timeValid` are all 0.
- R2: The sub-second counter rises by one every cycle. In the cycle after it holds `SUB_MAX` it reads 0.
- R3: The seconds counter rises by one exactly on the edge where the sub-second counter wraps from `SUB_MAX` to 0. On every other edge with no load it holds its value.
- R4: `ppsPulse` is high for exactly the one cycle that follows a wrap. At that time `subOut` is 0. A load of the value 0 does not raise it.
- R5: A write with `wrSel` = 0 stages the seconds low word (all `DATA_W` bits). A write with `wrSel` = 1 stages the seconds high word (bits `SEC_W-DATA_W-1:0`). A write with `wrSel` = 2 stages the sub-second value. None of these writes changes the counters.
- R6: A write with `wrSel` = 3 and `wrData[0]` = 1 loads the seconds counter with {high, low} staged words on the following edge. The sub-second counter keeps counting untouched.
- R7: A write with `wrSel` = 3 and `wrData[1]` = 1 loads the sub-second counter with the staged value on the following edge, and the seconds counter is unchanged. If the counter held `SUB_MAX` on that edge, no seconds increment and no pulse occur. A staged value above `SUB_MAX` is clipped to `SUB_MAX` when it is written.
- R8: When both command bits are 1 in one write, both counters load on the same edge and no seconds increment is applied.
- R9: The commands are one-shot. Each acts for one cycle only. A command write whose bits 1:0 are 0 has no effect on the counters.
- R10: `timeValid` is 0 from reset until both counters have been loaded at least once since reset. It then stays 1 until the next reset.
- R11: If the seconds load lands on a wrap edge, the loaded value wins over the increment. The sub-second counter still wraps and `ppsPulse` still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the staging/command port |
| wrSel | input | 2 | Write target: 0 seconds low, 1 seconds high, 2 sub-second, 3 command |
| wrData | input | DATA_W | Write data; for a command, bit 0 loads seconds, bit 1 loads sub-second |
| secOut | output | SEC_W | Seconds counter |
| subOut | output | SUB_W | Sub-second cycle counter |
| ppsPulse | output | 1 | One-cycle pulse after each sub-second wrap |
| timeValid | output | 1 | Both counters have been loaded since reset |

## Verification
The bench builds the block with `DATA_W` = 8, `SEC_W` = 12, `SUB_W` = 4 and `SUB_MAX` = 9, so a full second lasts ten cycles. Each load command, alone and combined, can therefore be swept across every phase of the sub-second count. This brings the collisions of a load with the wrap edge (R7, R8, R11) within reach in a few hundred cycles. A 4-bit high word keeps the seconds roll-over and the clipping of oversize sub-second values short enough to reach directly.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Write-port targets
  typedef enum logic [1:0] {
    SEL_SEC_LO = 2'd0,
    SEL_SEC_HI = 2'd1,
    SEL_SUB    = 2'd2,
    SEL_CMD    = 2'd3
  } todSel_e;

  // Command bit positions inside wrData for SEL_CMD
  localparam int CMD_SEC_BIT = 0;
  localparam int CMD_SUB_BIT = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSec;
    logic loadSub;
  } todStrobe_t;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEC_W   = 40,
  parameter int SUB_W   = 27,
  parameter int SUB_MAX = 124999999
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output todStrobe_t        strb,
  output logic [SEC_W-1:0]  stagedSec,
  output logic [SUB_W-1:0]  stagedSub,
  output logic              timeValid
);

  localparam int HI_W = SEC_W - DATA_W;
  localparam logic [DATA_W-1:0] SUB_MAX_D = DATA_W'(SUB_MAX);
  localparam logic [SUB_W-1:0]  SUB_MAX_S = SUB_W'(SUB_MAX);

  logic [DATA_W-1:0] secLoReg;
  logic [HI_W-1:0]   secHiReg;
  logic [SUB_W-1:0]  subReg;
  logic [SUB_W-1:0]  subWrVal;
  logic              secDone;
  logic              subDone;
  logic              cmdHit;

  assign cmdHit = wrEn && (wrSel == SEL_CMD);

  // Clip an oversize sub-second value unless the counter range fills its width
  generate
    if (SUB_MAX == (2 ** SUB_W) - 1) begin : g_noClip
      assign subWrVal = wrData[SUB_W-1:0];
    end else begin : g_clip
      assign subWrVal = (wrData > SUB_MAX_D) ? SUB_MAX_S : wrData[SUB_W-1:0];
    end
  endgenerate

  // Staging registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secLoReg <= '0;
      secHiReg <= '0;
      subReg   <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_SEC_LO: secLoReg <= wrData;
        SEL_SEC_HI: secHiReg <= wrData[HI_W-1:0];
        SEL_SUB:    subReg   <= subWrVal;
        default:    ;
      endcase
    end
  end

  // Self-clearing one-shot strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb <= '0;
    end else begin
      strb.loadSec <= cmdHit && wrData[CMD_SEC_BIT];
      strb.loadSub <= cmdHit && wrData[CMD_SUB_BIT];
    end
  end

  // Loaded-since-reset tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secDone <= 1'b0;
      subDone <= 1'b0;
    end else begin
      secDone <= secDone | strb.loadSec;
      subDone <= subDone | strb.loadSub;
    end
  end

  assign stagedSec = {secHiReg, secLoReg};
  assign stagedSub = subReg;
  assign timeValid = secDone & subDone;

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int SEC_W   = 40,
  parameter int SUB_W   = 27,
  parameter int SUB_MAX = 124999999
) (
  input  logic             clk,
  input  logic             rstN,
  input  todStrobe_t       strb,
  input  logic [SEC_W-1:0] stagedSec,
  input  logic [SUB_W-1:0] stagedSub,
  output logic [SEC_W-1:0] secOut,
  output logic [SUB_W-1:0] subOut,
  output logic             ppsPulse
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_MAX);

  logic [SEC_W-1:0] secCnt;
  logic [SUB_W-1:0] subCnt;
  logic             atLast;
  logic             wrapNow;
  logic             ppsReg;

  assign atLast  = (subCnt == SUB_LAST);
  assign wrapNow = atLast && !strb.loadSub;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (strb.loadSub) begin
      subCnt <= stagedSub;
    end else if (atLast) begin
      subCnt <= '0;
    end else begin
      subCnt <= subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt <= '0;
    end else if (strb.loadSec) begin
      secCnt <= stagedSec;
    end else if (wrapNow) begin
      secCnt <= secCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ppsReg <= 1'b0;
    else       ppsReg <= wrapNow;
  end

  assign secOut   = secCnt;
  assign subOut   = subCnt;
  assign ppsPulse = ppsReg;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SEC_W   = 40,
  parameter int SUB_W   = 27,
  parameter int SUB_MAX = 124999999
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  secOut,
  output logic [SUB_W-1:0]  subOut,
  output logic              ppsPulse,
  output logic              timeValid
);

  todStrobe_t       strbBus;
  logic [SEC_W-1:0] stagedSec;
  logic [SUB_W-1:0] stagedSub;

  tod_ctrl #(
    .DATA_W (DATA_W),
    .SEC_W  (SEC_W),
    .SUB_W  (SUB_W),
    .SUB_MAX(SUB_MAX)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .strb     (strbBus),
    .stagedSec(stagedSec),
    .stagedSub(stagedSub),
    .timeValid(timeValid)
  );

  tod_datapath #(
    .SEC_W  (SEC_W),
    .SUB_W  (SUB_W),
    .SUB_MAX(SUB_MAX)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strbBus),
    .stagedSec(stagedSec),
    .stagedSub(stagedSub),
    .secOut   (secOut),
    .subOut   (subOut),
    .ppsPulse (ppsPulse)
  );

endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter int SEC_W   = 40,
  parameter int SUB_W   = 27,
  parameter int SUB_MAX = 124999999
) (
  input logic             clk,
  input logic             rstN,
  input todStrobe_t       strb,
  input logic [SEC_W-1:0] secOut,
  input logic [SUB_W-1:0] subOut,
  input logic             ppsPulse,
  input logic             timeValid
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_MAX);

  a_r2_sub_range: assert property (@(posedge clk) disable iff (!rstN)
    subOut <= SUB_LAST);

  a_r2_sub_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSub && subOut != SUB_LAST) |=> subOut == SUB_W'($past(subOut) + 1'b1));

  a_r2_sub_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSub && subOut == SUB_LAST) |=> subOut == '0);

  a_r3_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSec && subOut != SUB_LAST) |=> $stable(secOut));

  a_r3_sec_inc: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSec && !strb.loadSub && subOut == SUB_LAST)
      |=> (secOut == SEC_W'($past(secOut) + 1'b1)));

  a_r4_pps_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    ppsPulse |-> subOut == '0);

  a_r4_pps_single: assert property (@(posedge clk) disable iff (!rstN)
    ppsPulse |=> !ppsPulse);

  a_r7_no_pps_on_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSub |=> !ppsPulse);

  a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeValid |=> timeValid);

endmodule

bind tod_counter tod_checker #(
  .SEC_W  (SEC_W),
  .SUB_W  (SUB_W),
  .SUB_MAX(SUB_MAX)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strbBus),
  .secOut   (secOut),
  .subOut   (subOut),
  .ppsPulse (ppsPulse),
  .timeValid(timeValid)
);

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;

  localparam int DATA_W  = 8;
  localparam int SEC_W   = 12;
  localparam int SUB_W   = 4;
  localparam int SUB_MAX = 9;
  localparam int HI_W    = SEC_W - DATA_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrSel = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [SEC_W-1:0]  secOut;
  logic [SUB_W-1:0]  subOut;
  logic              ppsPulse;
  logic              timeValid;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string curTag = "R2";

  always #5 clk = ~clk;

  tod_counter #(
    .DATA_W (DATA_W),
    .SEC_W  (SEC_W),
    .SUB_W  (SUB_W),
    .SUB_MAX(SUB_MAX)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .secOut   (secOut),
    .subOut   (subOut),
    .ppsPulse (ppsPulse),
    .timeValid(timeValid)
  );

  // Reference model built from the requirements
  logic              mPendSec, mPendSub, mSecDone, mSubDone, mPps;
  logic [DATA_W-1:0] mStLo;
  logic [HI_W-1:0]   mStHi;
  logic [SUB_W-1:0]  mStSub, mSub;
  logic [SEC_W-1:0]  mSec;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPendSec <= 0; mPendSub <= 0; mSecDone <= 0; mSubDone <= 0; mPps <= 0;
      mStLo <= '0; mStHi <= '0; mStSub <= '0; mSub <= '0; mSec <= '0;
    end else begin
      mPendSec <= wrEn && wrSel == 2'd3 && wrData[0];
      mPendSub <= wrEn && wrSel == 2'd3 && wrData[1];
      if (wrEn && wrSel == 2'd0) mStLo <= wrData;
      if (wrEn && wrSel == 2'd1) mStHi <= wrData[HI_W-1:0];
      if (wrEn && wrSel == 2'd2) mStSub <= (wrData > SUB_MAX) ? SUB_W'(SUB_MAX) : wrData[SUB_W-1:0];
      if (mPendSub) mSub <= mStSub;
      else if (mSub == SUB_MAX) mSub <= '0;
      else mSub <= mSub + 1'b1;
      if (mPendSec) mSec <= {mStHi, mStLo};
      else if (mSub == SUB_MAX && !mPendSub) mSec <= mSec + 1'b1;
      mPps <= (mSub == SUB_MAX) && !mPendSub;
      mSecDone <= mSecDone | mPendSec;
      mSubDone <= mSubDone | mPendSub;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk({curTag, " subOut"}, 32'(subOut), 32'(mSub));
      chk({curTag, " secOut"}, 32'(secOut), 32'(mSec));
      chk({curTag, " ppsPulse"}, 32'(ppsPulse), 32'(mPps));
      chk({curTag, " timeValid"}, 32'(timeValid), 32'(mSecDone & mSubDone));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [SUB_W-1:0] s0;
    logic [SEC_W-1:0] c0;
    // R1: reset state
    idle(3);
    chk("R1 subOut", 32'(subOut), 0);
    chk("R1 secOut", 32'(secOut), 0);
    chk("R1 ppsPulse", 32'(ppsPulse), 0);
    chk("R1 timeValid", 32'(timeValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 first cycle subOut", 32'(subOut), 1);
    chk("R1 first cycle secOut", 32'(secOut), 0);
    // R2 R3 R4: free running over several seconds
    curTag = "R3";
    idle(9);
    chk("R4 pps after wrap", 32'(ppsPulse), 1);
    chk("R3 sec after wrap", 32'(secOut), 1);
    chk("R2 sub after wrap", 32'(subOut), 0);
    idle(35);
    // R5: staging writes leave counters alone
    curTag = "R5";
    s0 = subOut;
    wr(2'd0, 8'hA5);
    chk("R5 sub unaffected", 32'(subOut), 32'((s0 + 2) % 10));
    wr(2'd1, 8'hF3);
    wr(2'd2, 8'd7);
    chk("R10 valid before loads", 32'(timeValid), 0);
    // R6: seconds load
    curTag = "R6";
    s0 = subOut;
    wr(2'd3, 8'h01);
    @(negedge clk);
    chk("R6 sec loaded", 32'(secOut), 32'h3A5);
    chk("R6 sub untouched", 32'(subOut), 32'((s0 + 3) % 10));
    chk("R10 valid after sec only", 32'(timeValid), 0);
    // R7: sub-second load
    curTag = "R7";
    wr(2'd3, 8'h02);
    c0 = secOut;
    @(negedge clk);
    chk("R7 sub loaded", 32'(subOut), 7);
    chk("R7 sec unchanged", 32'(secOut), 32'(c0));
    chk("R10 valid after both", 32'(timeValid), 1);
    // R7: clipping of oversize staged value, then wrap
    wr(2'd2, 8'd15);
    wr(2'd3, 8'h02);
    @(negedge clk);
    chk("R7 clipped sub", 32'(subOut), 9);
    c0 = secOut;
    @(negedge clk);
    chk("R2 wrap after clip", 32'(subOut), 0);
    chk("R4 pps after clip wrap", 32'(ppsPulse), 1);
    chk("R3 sec inc after clip wrap", 32'(secOut), 32'((c0 + 1) % 4096));
    // R4: load of zero does not pulse
    wr(2'd2, 8'd0);
    idle(4);
    wr(2'd3, 8'h02);
    @(negedge clk);
    chk("R4 zero load sub", 32'(subOut), 0);
    chk("R4 zero load no pps", 32'(ppsPulse), 0);
    // R8: both at once
    curTag = "R8";
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'd4);
    wr(2'd3, 8'h03);
    @(negedge clk);
    chk("R8 sec loaded", 32'(secOut), 32'h211);
    chk("R8 sub loaded", 32'(subOut), 4);
    // R9: zero command and one-shot behaviour
    curTag = "R9";
    s0 = subOut; c0 = secOut;
    wr(2'd3, 8'h00);
    chk("R9 zero cmd sub", 32'(subOut), 32'((s0 + 2) % 10));
    idle(6);
    chk("R9 no reload sub", 32'(subOut), 32'((s0 + 8) % 10));
    chk("R9 no reload sec", 32'(secOut), 32'((c0 + 1) % 4096));
    // Phase sweeps: each command at every sub-second phase
    wr(2'd2, 8'd9);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h0F);
    for (int code = 1; code <= 3; code++) begin
      curTag = (code == 1) ? "R11" : (code == 2) ? "R7" : "R8";
      for (int k = 0; k <= SUB_MAX; k++) begin
        idle(k);
        wr(2'd3, 8'(code));
        idle(12);
      end
    end
    // Seconds roll-over from all ones
    curTag = "R3";
    idle(25);
    finishRun();
  end

endmodule